// File: doc/BRIEF.md
# External Clock Bypass and Divided-Clock Control

This block decides when the chip should run from an externally supplied clock, and how the two clocks divided from the IO clock behave while that happens. Two independent sources can ask for the bypass. Software asks through a control register, but only while a debug-enable pin allows it. The life cycle controller asks through a dedicated request pin, whatever the registers hold. All selection and request values use redundant four-bit codes. Any value other than the one legal "on" code counts as off.

The block drives two bypass request outputs toward the analog clock source. One is an IO-clock request that tracks the life cycle pin. The other is an all-clocks request that tracks the software path. It also models the divide-by-2 and divide-by-4 clocks as one-cycle tick enables on the IO clock. While the external clock is in use, both dividers run twice as fast if either of these holds:
- the life cycle controller made the request;
- software made the request with its high-speed field set.

Scan mode cancels this speed-up. A jitter-enable output mirrors a register field. Register-sourced controls pass through a synchronizer. Pin-sourced controls act directly.

Top module: `byp_extclk_ctrl`

## Requirements
- R1: After reset the four-bit request outputs hold the off code 4'b0101. The control register reads 8'h99. The jitter register reads 8'h09, and `jitter_en_o` is 4'b1001.
- R2: `all_byp_req_o` shows the on code only when both of these hold:
  - the synchronized select field (control register bits [3:0]) is exactly 4'b0110;
  - `dbg_en_i` is exactly 4'b1010.
  Any other select value, including 4'b0000, counts as false.
- R3: `io_byp_req_o` follows `lc_byp_req_i` one clock later. It is on exactly when the pin held 4'b1010 at the previous edge.
- R4: Both request outputs only ever carry the on code 4'b1010 or the off code 4'b0101.
- R5: With no step-down, `div2_tick_o` pulses once every 2 cycles and `div4_tick_o` once every 4 cycles.
- R6: When `lc_byp_req_i` is 4'b1010 and `scan_mode_i` is not 4'b0110, the step-down applies: `div2_tick_o` pulses every cycle and `div4_tick_o` every 2 cycles.
- R7: A software request applies the step-down only when the synchronized high-speed field (control register bits [7:4]) is exactly 4'b0110. Otherwise the dividers stay at the R5 rates.
- R8: While `scan_mode_i` is 4'b0110, the dividers stay at the R5 rates whatever the requests are.
- R9: A divider changes its ratio only at the end of a period. Gaps between `div2_tick_o` pulses are always 1 or 2 cycles. Gaps between `div4_tick_o` pulses are always 2 or 4 cycles.
- R10: `jitter_en_o` equals register field bits [3:0] at address 1 from the edge that writes it onward. It changes at no other time.
- R11: A write to the select field reaches `all_byp_req_o` after exactly SYNC_STAGES further clock edges. A change of `dbg_en_i` acts at once.
- R12: Register reads on `reg_rdata_o` are combinational from `reg_addr_i`:
  - address 0 returns {high-speed, select};
  - address 1 returns the jitter field zero-extended;
  - any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | IO clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | REG_DW | Register write data |
| reg_rdata_o | output | REG_DW | Register read data |
| dbg_en_i | input | 4 | Debug enable, on code 4'b1010 |
| lc_byp_req_i | input | 4 | Life cycle bypass request, on code 4'b1010 |
| scan_mode_i | input | 4 | Scan mode, true code 4'b0110 |
| io_byp_req_o | output | 4 | IO-clock bypass request |
| all_byp_req_o | output | 4 | All-clocks bypass request |
| jitter_en_o | output | 4 | Jitter enable field |
| div2_tick_o | output | 1 | Divide-by-2 clock tick |
| div4_tick_o | output | 1 | Divide-by-4 clock tick |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. The exact cycle in which a register write reaches the all-clocks request therefore checks the depth parameter, not a hard-coded latency. The divider counter width stays at its default of 3, which just holds the nominal divide-by-4 count. Because of this, the halved and nominal ratios and every switch between them at a period boundary can all be reached.

// File: rtl/byp_pkg.sv
package byp_pkg;

    typedef logic [3:0] mubi4_t;
    typedef logic [3:0] lc4_t;

    localparam mubi4_t MUBI_TRUE  = 4'b0110;
    localparam mubi4_t MUBI_FALSE = 4'b1001;
    localparam lc4_t   LC_ON      = 4'b1010;
    localparam lc4_t   LC_OFF     = 4'b0101;

    localparam int ADDR_EXT = 0;
    localparam int ADDR_JIT = 1;

    typedef struct packed {
        mubi4_t hi_speed;
        mubi4_t sel;
    } ext_ctrl_t;

    localparam ext_ctrl_t CTRL_RESET = '{hi_speed: MUBI_FALSE, sel: MUBI_FALSE};

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SW   = 2'd1,
        SRC_LC   = 2'd2
    } ext_src_e;

    function automatic logic mubi_true(input mubi4_t v);
        return v == MUBI_TRUE;
    endfunction

    function automatic logic lc_is_on(input lc4_t v);
        return v == LC_ON;
    endfunction

    function automatic lc4_t lc_code(input logic on);
        return on ? LC_ON : LC_OFF;
    endfunction

endpackage

// File: rtl/byp_regs.sv
module byp_regs
    import byp_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int REG_DW = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_DW-1:0] wdata_i,
    output logic [REG_DW-1:0] rdata_o,
    output ext_ctrl_t         ctrl_o,
    output mubi4_t            jit_o
);

    localparam int CTRL_W = $bits(ext_ctrl_t);

    ext_ctrl_t ctrl_q;
    mubi4_t    jit_q;
    logic      hit_ext, hit_jit;
    logic      unused_wdata;

    assign hit_ext      = addr_i == ADDR_W'(ADDR_EXT);
    assign hit_jit      = addr_i == ADDR_W'(ADDR_JIT);
    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= CTRL_RESET;
            jit_q  <= MUBI_FALSE;
        end else if (we_i) begin
            if (hit_ext) ctrl_q <= ext_ctrl_t'(wdata_i[CTRL_W-1:0]);
            if (hit_jit) jit_q  <= mubi4_t'(wdata_i[3:0]);
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit_ext)      rdata_o = REG_DW'(ctrl_q);
        else if (hit_jit) rdata_o = REG_DW'(jit_q);
    end

    assign ctrl_o = ctrl_q;
    assign jit_o  = jit_q;

endmodule

// File: rtl/byp_sync.sv
module byp_sync #(
    parameter int           W         = 8,
    parameter int           STAGES    = 2,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
        if (gs == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q[gs] <= RESET_VAL;
                else       stage_q[gs] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q[gs] <= RESET_VAL;
                else       stage_q[gs] <= stage_q[gs-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/byp_clkdiv.sv
module byp_clkdiv #(
    parameter int CNT_W   = 3,
    parameter int NOMINAL = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    output logic tick_o
);

    localparam logic [CNT_W-1:0] NOM  = CNT_W'(NOMINAL);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(NOMINAL / 2);

    logic [CNT_W-1:0] cnt_q, ratio_q, ratio_d;
    logic             last, tick_q;

    assign last    = cnt_q == ratio_q - CNT_W'(1);
    assign ratio_d = step_i ? HALF : NOM;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            ratio_q <= NOM;
            tick_q  <= 1'b0;
        end else if (last) begin
            cnt_q   <= '0;
            ratio_q <= ratio_d;
            tick_q  <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
            tick_q  <= 1'b0;
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/byp_extclk_ctrl.sv
module byp_extclk_ctrl
    import byp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2,
    parameter int REG_DW      = 8,
    parameter int CNT_W       = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    input  logic [3:0]        dbg_en_i,
    input  logic [3:0]        lc_byp_req_i,
    input  logic [3:0]        scan_mode_i,
    output logic [3:0]        io_byp_req_o,
    output logic [3:0]        all_byp_req_o,
    output logic [3:0]        jitter_en_o,
    output logic              div2_tick_o,
    output logic              div4_tick_o
);

    localparam int CTRL_W = $bits(ext_ctrl_t);
    localparam int N_DIV  = 2;

    ext_ctrl_t         ctrl_q, ctrl_s;
    logic [CTRL_W-1:0] ctrl_s_raw;
    mubi4_t            jit_q;
    ext_src_e          src;
    logic              sw_req, lc_req, step;
    lc4_t              io_req_q;
    logic [N_DIV-1:0]  ticks;

    byp_regs #(.ADDR_W(ADDR_W), .REG_DW(REG_DW)) u_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .ctrl_o  (ctrl_q),
        .jit_o   (jit_q)
    );

    byp_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RESET_VAL(CTRL_RESET)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (ctrl_q),
        .q_o   (ctrl_s_raw)
    );
    assign ctrl_s = ext_ctrl_t'(ctrl_s_raw);

    assign sw_req = mubi_true(ctrl_s.sel) && lc_is_on(dbg_en_i);
    assign lc_req = lc_is_on(lc_byp_req_i);

    always_comb begin
        if (lc_req)      src = SRC_LC;
        else if (sw_req) src = SRC_SW;
        else             src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_LC:  step = 1'b1;
            SRC_SW:  step = mubi_true(ctrl_s.hi_speed);
            default: step = 1'b0;
        endcase
        if (mubi_true(scan_mode_i)) step = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) io_req_q <= LC_OFF;
        else       io_req_q <= lc_code(lc_req);
    end

    for (genvar gd = 0; gd < N_DIV; gd++) begin : g_div
        byp_clkdiv #(.CNT_W(CNT_W), .NOMINAL(2 << gd)) u_div (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .step_i (step),
            .tick_o (ticks[gd])
        );
    end

    assign io_byp_req_o  = io_req_q;
    assign all_byp_req_o = lc_code(sw_req);
    assign jitter_en_o   = jit_q;
    assign div2_tick_o   = ticks[0];
    assign div4_tick_o   = ticks[1];

endmodule

// File: rtl/byp_extclk_ctrl_chk.sv
module byp_extclk_ctrl_chk #(
    parameter int ADDR_W = 2
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [3:0]        dbg_en_i,
    input logic [3:0]        lc_byp_req_i,
    input logic [3:0]        io_byp_req_o,
    input logic [3:0]        all_byp_req_o,
    input logic [3:0]        jitter_en_o,
    input logic              div4_tick_o
);

    p_io_req_on_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (lc_byp_req_i == 4'b1010) |=> (io_byp_req_o == 4'b1010));

    p_io_req_off_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (lc_byp_req_i != 4'b1010) |=> (io_byp_req_o == 4'b0101));

    p_req_codes_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (all_byp_req_o == 4'b1010 || all_byp_req_o == 4'b0101) &&
        (io_byp_req_o == 4'b1010 || io_byp_req_o == 4'b0101));

    p_all_req_needs_dbg_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (dbg_en_i != 4'b1010) |-> (all_byp_req_o == 4'b0101));

    p_div4_min_gap_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        div4_tick_o |=> !div4_tick_o);

    p_jitter_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !(reg_we_i && reg_addr_i == ADDR_W'(1)) |=> $stable(jitter_en_o));

endmodule

bind byp_extclk_ctrl byp_extclk_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_addr_i),
    .dbg_en_i      (dbg_en_i),
    .lc_byp_req_i  (lc_byp_req_i),
    .io_byp_req_o  (io_byp_req_o),
    .all_byp_req_o (all_byp_req_o),
    .jitter_en_o   (jitter_en_o),
    .div4_tick_o   (div4_tick_o)
);

// File: tb/sim_byp_extclk_ctrl.sv
module sim_byp_extclk_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC_N     = 3;
    localparam logic [3:0] T_ = 4'b0110, F_ = 4'b1001, ON = 4'b1010, OFF = 4'b0101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] dbg = OFF, lc = OFF, scan = F_;
    logic [3:0] io_req, all_req, jit;
    logic       t2, t4;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byp_extclk_ctrl #(.SYNC_STAGES(SYNC_N)) u0 (
        .clk_i(clk), .rst_i(rst), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dbg_en_i(dbg),
        .lc_byp_req_i(lc), .scan_mode_i(scan), .io_byp_req_o(io_req),
        .all_byp_req_o(all_req), .jitter_en_o(jit), .div2_tick_o(t2), .div4_tick_o(t4)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_all(input logic [3:0] sel, input logic [3:0] d);
        return (sel == T_ && d == ON) ? ON : OFF;
    endfunction

    function automatic bit exp_step(input logic [3:0] sel, hs, d, l, s);
        bit sw = (sel == T_) && (d == ON);
        if (s == T_) return 1'b0;
        return (l == ON) || (sw && hs == T_);
    endfunction

    // R9: gap monitor at every tick, across all modes and transitions
    int  g2 = 0, g4 = 0;
    bit  s2 = 0, s4 = 0;
    always @(negedge clk) begin
        if (rst) begin
            s2 = 0; s4 = 0;
        end else begin
            if (t2) begin
                if (s2 && !(g2 == 1 || g2 == 2)) chk("R9 div2 gap", g2, 2);
                s2 = 1; g2 = 1;
            end else g2++;
            if (t4) begin
                if (s4 && !(g4 == 2 || g4 == 4)) chk("R9 div4 gap", g4, 4);
                s4 = 1; g4 = 1;
            end else g4++;
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic measure(input bit step, input string req);
        int e2 = step ? 1 : 2;
        int e4 = step ? 2 : 4;
        int a2 = 0, a4 = 0, bad2 = -1, bad4 = -1;
        bit m2 = 0, m4 = 0;
        repeat (24) begin
            @(negedge clk);
            if (t2) begin
                if (m2 && a2 != e2) bad2 = a2;
                m2 = 1; a2 = 1;
            end else a2++;
            if (t4) begin
                if (m4 && a4 != e4) bad4 = a4;
                m4 = 1; a4 = 1;
            end else a4++;
        end
        chk({req, " div2 period"}, (bad2 < 0 && m2) ? e2 : bad2, e2);
        chk({req, " div4 period"}, (bad4 < 0 && m4) ? e4 : bad4, e4);
    endtask

    task automatic apply(input logic [3:0] sel, hs, d, l, s, input string req);
        reg_wr(2'd0, {hs, sel});
        dbg = d; lc = l; scan = s;
        repeat (12) @(negedge clk);
        chk({req, " all_byp_req"}, all_req, exp_all(sel, d));
        chk({req, " io_byp_req"}, io_req, (l == ON) ? ON : OFF);
        reg_addr = 2'd0; #1;
        chk({req, " R12 readback ctrl"}, reg_rdata, {hs, sel});
        measure(exp_step(sel, hs, d, l, s), req);
    endtask

    function automatic logic [3:0] pick_mubi(input bit is_lc);
        int unsigned r = $urandom % 4;
        if (r == 0 || r == 3) return is_lc ? ON : T_;
        if (r == 1) return is_lc ? OFF : F_;
        return 4'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd5713));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 io_byp_req", io_req, OFF);
        chk("R1 all_byp_req", all_req, OFF);
        chk("R1 jitter_en", jit, F_);
        reg_addr = 2'd0; #1; chk("R1 ctrl read", reg_rdata, 8'h99);
        reg_addr = 2'd1; #1; chk("R1 jitter read", reg_rdata, 8'h09);
        reg_addr = 2'd2; #1; chk("R12 unmapped read", reg_rdata, 8'h00);
        reg_addr = 2'd0;
        measure(1'b0, "R5 nominal");

        // R10 jitter field
        reg_wr(2'd1, 8'hF6);
        chk("R10 jitter after write", jit, T_);
        reg_addr = 2'd1; #1; chk("R12 jitter read", reg_rdata, 8'h06);
        reg_wr(2'd0, 8'h99);
        chk("R10 jitter unaffected by ctrl write", jit, T_);

        // R11 sync depth and immediate pin path
        dbg = ON;
        reg_wr(2'd0, {F_, T_});
        repeat (SYNC_N - 1) @(negedge clk);
        chk("R11 before sync depth", all_req, OFF);
        @(negedge clk);
        chk("R11 at sync depth", all_req, ON);
        dbg = 4'b1011; #1;
        chk("R11 dbg acts at once", all_req, OFF);
        dbg = ON; #1;

        // R3 one-cycle follow
        lc = ON; #1;
        chk("R3 before edge", io_req, OFF);
        @(negedge clk);
        chk("R3 after edge", io_req, ON);
        lc = 4'b1011;
        @(negedge clk);
        chk("R3 near-miss code off", io_req, OFF);

        // directed modes
        apply(F_, F_, OFF, ON,  F_, "R6 lc step");
        apply(F_, F_, OFF, ON,  T_, "R8 scan blocks lc");
        apply(T_, T_, ON,  OFF, F_, "R7 sw hi-speed");
        apply(T_, F_, ON,  OFF, F_, "R7 sw no hi-speed");
        apply(T_, T_, ON,  OFF, T_, "R8 scan blocks sw");
        apply(T_, T_, 4'b1110, OFF, F_, "R2 bad dbg");
        apply(4'b0000, T_, ON, OFF, F_, "R2 zero sel");
        apply(4'b0111, T_, ON, OFF, F_, "R2 near-miss sel");
        apply(F_, F_, OFF, OFF, F_, "R5 all off");

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [3:0] rs = pick_mubi(1'b0), rh = pick_mubi(1'b0);
            logic [3:0] rd = pick_mubi(1'b1), rl = pick_mubi(1'b1);
            logic [3:0] rc = ($urandom % 4 == 0) ? T_ : F_;
            apply(rs, rh, rd, rl, rc, "R6/R7/R2 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule